// File: doc/BRIEF.md
# Native Clock Sleep/Wake Controller

This block keeps the free-running native slot clock of a radio baseband and runs its power-down and wake-up sequence. The clock advances by one on every system tick pulse. A command, together with two configuration bytes, arrives on a one-cycle valid strobe. The low byte and the low nibble of the second byte form one 12-bit parameter, and the command decides what the parameter means. A transmit command records it as the number of bits to send. A power-down command records it as the wake point on the low 12 bits of the native clock. A change-to-slave-clock command may preload it into those low 12 bits.

After the clock reaches the wake point, the block runs a power-up sequence that lasts a fixed number of system ticks. It then reports that it is ready again. Bit 4 of the second byte is a clock-load flag, and only the change-to-slave-clock command honours it. Commands are accepted only while the block is ready.

Top module: `natclk_sleep_ctrl`

## Requirements
- R1: Out of reset `nat_clk` is 0, `ready` is 1, `sleeping` and `powering_up` are 0, and `tx_bits` is 0.
- R2: Each cycle with `tick` high and no clock load advances `nat_clk` by one. It wraps over its full width, so a carry out of the low 12 bits increments the upper bits. With no tick and no load, `nat_clk` holds.
- R3: The parameter is `{cfg_hi[3:0], cfg_lo}`. A transmit command (`cmd` = 0) accepted while ready copies it into `tx_bits` on the next cycle and does not touch the clock.
- R4: A change-to-slave-clock command (`cmd` = 2) with `cfg_hi[4]` = 1, accepted while ready, replaces `nat_clk[11:0]` with the parameter and leaves the upper bits unchanged. The load takes priority over a tick in the same cycle.
- R5: With `cfg_hi[4]` = 0 the change-to-slave-clock command leaves the clock unchanged. `cfg_hi[4]` has no effect for `cmd` = 0, 1 (power-down) or 3 (no operation).
- R6: A power-down command (`cmd` = 1) accepted while ready makes `sleeping` 1 and `ready` 0 on the next cycle and stores the parameter as the wake point. This also holds right after a previous wake-up.
- R7: While sleeping, a tick that brings `nat_clk[11:0]` equal to the wake point ends sleep one cycle later, and `powering_up` rises at that time. Ticks that give any other value keep the block asleep.
- R8: During power-up, `ready` returns, and `powering_up` clears, on the cycle after the 3rd tick of the power-up phase, and not earlier.
- R9: While `ready` is 0, every command is ignored: no clock load, no change of `tx_bits`, no restart of the sleep state.
- R10: Exactly one of `ready`, `sleeping` and `powering_up` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | System tick pulse, one cycle wide |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | 0 transmit, 1 power-down, 2 change-to-slave-clock, 3 no operation |
| cfg_lo | input | 8 | Configuration byte holding the parameter's low byte |
| cfg_hi | input | 8 | Configuration byte: bits 3:0 are the parameter's high nibble, bit 4 is the clock-load flag |
| nat_clk | output | NCLK_W | Native clock |
| tx_bits | output | 12 | Last accepted transmit bit count |
| sleeping | output | 1 | Power-down state |
| powering_up | output | 1 | Power-up sequence in progress |
| ready | output | 1 | Full power, commands accepted |

## Verification
The hardest situation to reach from the ports is a wake point that lies behind the current clock value. There the low 12 bits must wrap through zero before they match, and the carry into the upper clock bits happens while the block is asleep. The bench preloads the clock with a slave-clock command and then issues a power-down whose wake point is just below the loaded value. It then drives several thousand ticks, checking that the block stays asleep until the match, that the upper bits have carried, and that commands sent during sleep and during power-up are ignored.

// File: rtl/natclk_pkg.sv
package natclk_pkg;

    localparam int FIELD_W  = 12;
    localparam int LOAD_BIT = 4;

    typedef enum logic [1:0] {
        CMD_XMIT  = 2'd0,
        CMD_PDOWN = 2'd1,
        CMD_SLAVE = 2'd2,
        CMD_NOP   = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_SLEEP = 2'd1,
        PS_WAKE  = 2'd2
    } pstate_e;

endpackage

// File: rtl/ncs_field_decode.sv
module ncs_field_decode
    import natclk_pkg::*;
(
    input  logic               cmd_valid_i,
    input  logic [1:0]         cmd_i,
    input  logic [7:0]         cfg_lo_i,
    input  logic [7:0]         cfg_hi_i,
    input  logic               ready_i,
    output logic [FIELD_W-1:0] param_o,
    output logic               do_xmit_o,
    output logic               do_pdown_o,
    output logic               do_load_o
);

    logic accept;
    cmd_e kind;
    logic unused_hi_bits;

    assign unused_hi_bits = ^cfg_hi_i[7:5];

    always_comb begin
        param_o    = {cfg_hi_i[3:0], cfg_lo_i};
        kind       = cmd_e'(cmd_i);
        accept     = cmd_valid_i && ready_i;
        do_xmit_o  = accept && (kind == CMD_XMIT);
        do_pdown_o = accept && (kind == CMD_PDOWN);
        do_load_o  = accept && (kind == CMD_SLAVE) && cfg_hi_i[LOAD_BIT];
    end

endmodule

// File: rtl/ncs_native_clock.sv
module ncs_native_clock #(
    parameter int NCLK_W = 28,
    parameter int CMP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [CMP_W-1:0]  load_val_i,
    output logic [NCLK_W-1:0] nat_clk_o,
    output logic              stepped_o
);

    localparam logic [NCLK_W-1:0] STEP = NCLK_W'(1);

    typedef struct packed {
        logic [NCLK_W-1:0] cnt;
        logic              stepped;
    } clk_state_t;

    clk_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.stepped = 1'b0;
        if (load_i) begin
            s_d.cnt = {s_q.cnt[NCLK_W-1:CMP_W], load_val_i};
        end else if (tick_i) begin
            s_d.cnt     = s_q.cnt + STEP;
            s_d.stepped = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign nat_clk_o = s_q.cnt;
    assign stepped_o = s_q.stepped;

endmodule

// File: rtl/ncs_power_seq.sv
module ncs_power_seq
    import natclk_pkg::*;
#(
    parameter int CMP_W       = 12,
    parameter int PWRUP_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             stepped_i,
    input  logic [CMP_W-1:0] nat_low_i,
    input  logic             pdown_i,
    input  logic [CMP_W-1:0] wake_val_i,
    output logic             sleeping_o,
    output logic             powering_up_o,
    output logic             ready_o
);

    localparam int CNT_W = $clog2(PWRUP_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_TICKS - 1);
    localparam logic [CNT_W-1:0] INC  = CNT_W'(1);

    typedef struct packed {
        pstate_e          st;
        logic [CMP_W-1:0] wake;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            PS_RUN: begin
                if (pdown_i) begin
                    s_d.st   = PS_SLEEP;
                    s_d.wake = wake_val_i;
                end
            end
            PS_SLEEP: begin
                if (stepped_i && (nat_low_i == s_q.wake)) begin
                    s_d.st  = PS_WAKE;
                    s_d.cnt = '0;
                end
            end
            PS_WAKE: begin
                if (tick_i) begin
                    if (s_q.cnt == LAST) begin
                        s_d.st  = PS_RUN;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + INC;
                    end
                end
            end
            default: s_d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PS_RUN, wake: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o       = (s_q.st == PS_RUN);
    assign sleeping_o    = (s_q.st == PS_SLEEP);
    assign powering_up_o = (s_q.st == PS_WAKE);

endmodule

// File: rtl/natclk_sleep_ctrl.sv
module natclk_sleep_ctrl
    import natclk_pkg::*;
#(
    parameter int NCLK_W      = 28,
    parameter int PWRUP_TICKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd,
    input  logic [7:0]          cfg_lo,
    input  logic [7:0]          cfg_hi,
    output logic [NCLK_W-1:0]   nat_clk,
    output logic [FIELD_W-1:0]  tx_bits,
    output logic                sleeping,
    output logic                powering_up,
    output logic                ready
);

    logic [FIELD_W-1:0] param;
    logic               do_xmit;
    logic               do_pdown;
    logic               do_load;
    logic               stepped;
    logic [FIELD_W-1:0] tx_d, tx_q;

    ncs_field_decode u_dec (
        .cmd_valid_i (cmd_valid),
        .cmd_i       (cmd),
        .cfg_lo_i    (cfg_lo),
        .cfg_hi_i    (cfg_hi),
        .ready_i     (ready),
        .param_o     (param),
        .do_xmit_o   (do_xmit),
        .do_pdown_o  (do_pdown),
        .do_load_o   (do_load)
    );

    ncs_native_clock #(
        .NCLK_W (NCLK_W),
        .CMP_W  (FIELD_W)
    ) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (do_load),
        .load_val_i (param),
        .nat_clk_o  (nat_clk),
        .stepped_o  (stepped)
    );

    ncs_power_seq #(
        .CMP_W       (FIELD_W),
        .PWRUP_TICKS (PWRUP_TICKS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .stepped_i     (stepped),
        .nat_low_i     (nat_clk[FIELD_W-1:0]),
        .pdown_i       (do_pdown),
        .wake_val_i    (param),
        .sleeping_o    (sleeping),
        .powering_up_o (powering_up),
        .ready_o       (ready)
    );

    always_comb begin
        tx_d = tx_q;
        if (do_xmit) begin
            tx_d = param;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_bits = tx_q;

endmodule

// File: rtl/ncs_sva_checker.sv
module ncs_sva_checker
    import natclk_pkg::*;
#(
    parameter int NCLK_W      = 28,
    parameter int PWRUP_TICKS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                cmd_valid,
    input logic [1:0]          cmd,
    input logic [7:0]          cfg_lo,
    input logic [7:0]          cfg_hi,
    input logic [NCLK_W-1:0]   nat_clk,
    input logic [FIELD_W-1:0]  tx_bits,
    input logic                sleeping,
    input logic                powering_up,
    input logic                ready
);

    logic load_req;
    assign load_req = cmd_valid && ready && (cmd == 2'd2) && cfg_hi[LOAD_BIT];

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ready, sleeping, powering_up}) == 1);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_req) |=> (nat_clk == $past(nat_clk) + NCLK_W'(1)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_req) |=> $stable(nat_clk));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> ((nat_clk[FIELD_W-1:0] == $past({cfg_hi[3:0], cfg_lo}))
                      && (nat_clk[NCLK_W-1:FIELD_W] == $past(nat_clk[NCLK_W-1:FIELD_W]))));

    p_xmit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ready && (cmd == 2'd0)) |=> (tx_bits == $past({cfg_hi[3:0], cfg_lo})));

    p_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ready && (cmd == 2'd1)) |=> sleeping);

    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleeping) |-> powering_up);

    p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(powering_up) && $past(tick)));

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(tx_bits));

endmodule

bind natclk_sleep_ctrl ncs_sva_checker #(
    .NCLK_W      (NCLK_W),
    .PWRUP_TICKS (PWRUP_TICKS)
) u_sva_chk (.*);

// File: tb/natclk_sleep_ctrl_tb_top.sv
module natclk_sleep_ctrl_tb_top;

    localparam int NCLK_W = 28;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd = 2'd3;
    logic [7:0]        cfg_lo = '0;
    logic [7:0]        cfg_hi = '0;
    logic [NCLK_W-1:0] nat_clk;
    logic [11:0]       tx_bits;
    logic              sleeping, powering_up, ready;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [NCLK_W-1:0] exp_clk = '0;
    logic [11:0]       exp_tx = '0;

    always #4 clk = ~clk;

    natclk_sleep_ctrl #(.NCLK_W(NCLK_W), .PWRUP_TICKS(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd(cmd),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .nat_clk(nat_clk), .tx_bits(tx_bits),
        .sleeping(sleeping), .powering_up(powering_up), .ready(ready)
    );

    typedef struct packed {
        logic [1:0]  c;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [11:0] clk_low;
        logic [11:0] tx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h34, 8'h15, 12'h000, 12'h534},
        '{2'd2, 8'hBC, 8'h0A, 12'h000, 12'h534},
        '{2'd2, 8'hBC, 8'h1A, 12'hABC, 12'h534},
        '{2'd0, 8'h01, 8'hEF, 12'hABC, 12'hF01},
        '{2'd3, 8'hFF, 8'h1F, 12'hABC, 12'hF01},
        '{2'd2, 8'h00, 8'hF7, 12'h700, 12'hF01}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] c, input logic [7:0] lo, input logic [7:0] hi,
                        input logic with_tick);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; cfg_lo = lo; cfg_hi = hi; tick = with_tick;
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 2'd3; tick = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        exp_clk = exp_clk + NCLK_W'(1);
    endtask

    task automatic check_wake_sequence(input string tag);
        // cycle after the matching tick: stepped registered, still asleep
        chk({tag, " R7 asleep at match edge"}, 32'(sleeping), 32'd1);
        @(negedge clk);
        chk({tag, " R7 powering_up after match"}, 32'(powering_up), 32'd1);
        chk({tag, " R7 sleeping cleared"}, 32'(sleeping), 32'd0);
        // command during power-up is ignored
        send(2'd1, 8'h55, 8'h00, 1'b0);
        chk({tag, " R9 pdown ignored in power-up"}, 32'(powering_up), 32'd1);
        do_tick();
        chk({tag, " R8 not ready after 1 tick"}, 32'(ready), 32'd0);
        do_tick();
        chk({tag, " R8 not ready after 2 ticks"}, 32'(ready), 32'd0);
        do_tick();
        chk({tag, " R8 ready after 3 ticks"}, 32'(ready), 32'd1);
        chk({tag, " R8 powering_up cleared"}, 32'(powering_up), 32'd0);
        chk({tag, " R2 clock during power-up"}, 32'(nat_clk), 32'(exp_clk));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 nat_clk", 32'(nat_clk), 32'd0);
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 sleeping", 32'(sleeping), 32'd0);
        chk("R1 powering_up", 32'(powering_up), 32'd0);
        chk("R1 tx_bits", 32'(tx_bits), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 hold without tick", 32'(nat_clk), 32'd0);

        // vector table: R3 field assembly, R4 load, R5 flag gating
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].c, VECS[i].lo, VECS[i].hi, 1'b0);
            chk($sformatf("R3/R4/R5 vec %0d clock", i), 32'(nat_clk), 32'(VECS[i].clk_low));
            chk($sformatf("R3 vec %0d tx_bits", i), 32'(tx_bits), 32'(VECS[i].tx));
            chk($sformatf("R10 vec %0d ready", i), 32'(ready), 32'd1);
        end
        exp_clk = NCLK_W'(12'h700);
        exp_tx  = 12'hF01;

        // R2 ticking
        do_tick(); do_tick(); do_tick();
        chk("R2 three ticks", 32'(nat_clk), 32'(exp_clk));

        // R4 load wins over same-cycle tick
        send(2'd2, 8'h20, 8'h11, 1'b1);
        exp_clk = NCLK_W'(12'h120);
        chk("R4 load beats tick", 32'(nat_clk), 32'(exp_clk));

        // R6 power-down with flag set; R5 flag ignored for power-down
        send(2'd1, 8'h1F, 8'h10, 1'b0);
        chk("R5 pdown flag no load", 32'(nat_clk), 32'(exp_clk));
        chk("R6 sleeping", 32'(sleeping), 32'd1);
        chk("R6 ready low", 32'(ready), 32'd0);

        // R9 commands ignored while asleep
        send(2'd2, 8'h00, 8'h1F, 1'b0);
        chk("R9 load ignored asleep", 32'(nat_clk), 32'(exp_clk));
        send(2'd0, 8'h77, 8'h07, 1'b0);
        chk("R9 tx ignored asleep", 32'(tx_bits), 32'(exp_tx));
        send(2'd1, 8'h22, 8'h01, 1'b0);
        do_tick(); do_tick();
        @(negedge clk);
        chk("R9 no restart to 0x122", 32'(sleeping), 32'd1);

        // wrap through zero to wake point 0x01F
        while (exp_clk[11:0] != 12'h01E) do_tick();
        @(negedge clk);
        chk("R7 still asleep before match", 32'(sleeping), 32'd1);
        do_tick();
        chk("R2 carry into upper bits", 32'(nat_clk), 32'h0000101F);
        check_wake_sequence("wrap");

        // R6 restart after wake, near wake point
        send(2'd1, 8'h24, 8'h10, 1'b0);
        chk("R6 re-sleep", 32'(sleeping), 32'd1);
        chk("R5 flag ignored on re-sleep", 32'(nat_clk), 32'(exp_clk));
        while (exp_clk[11:0] != 12'h024) do_tick();
        check_wake_sequence("second");

        // R3 transmit after wake
        send(2'd0, 8'hAA, 8'h13, 1'b0);
        chk("R3 tx after wake", 32'(tx_bits), 32'h3AA);
        chk("R5 xmit flag no load", 32'(nat_clk), 32'(exp_clk));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule